// File: doc/BRIEF.md
# Packet Buffer with Status and Packet Flags

This block is the byte store that sits between a radio modem's serializer/deserializer and the host register file. It keeps up to 66 bytes in arrival order and drives a set of live status outputs: the buffer is full, the buffer holds data, the fill level is above a host-programmed threshold, and a write was lost because the buffer was full. It also drives three packet-level indications: a transmitted packet has fully left, a received payload is ready to read, and the received payload's checksum was good.

The serializer pushes bytes and the host pops them, or the other way round in transmit. The packet engine signals the final byte of each packet and supplies the checksum verdict. The host clears the lost-write indication by writing a one, and that same write empties the buffer at once so the next packet can start cleanly. Checksum computation, the serial bit path and the host bus protocol are outside this block.

Mode encoding on `mode_i`: 2'b00 sleep, 2'b01 idle, 2'b10 receive, 2'b11 transmit.

Top module: `pkt_fifo_flags`

## Requirements
- R1: The buffer holds exactly 66 bytes; `full_o` is high exactly when 66 bytes are stored. A push on a full buffer without a pop is discarded and leaves the stored data unchanged.
- R2: `nempty_o` is high exactly when at least one byte is stored.
- R3: `level_o` is high exactly when the stored count is strictly greater than `thresh_i`; equality leaves it low.
- R4: `overrun_o` is set by the edge on which `push_i` is high, `pop_i` is low and the buffer is full, unless `mode_i` is 2'b00 (sleep); it then stays set until cleared.
- R5: `ovr_clr_i` high on an edge clears `overrun_o` and empties the buffer; on that edge push and pop are ignored and `pop_data_o` holds.
- R6: Bytes leave in arrival order across pointer wraparound; after an edge with `pop_i` high on a non-empty buffer, `pop_data_o` shows the oldest byte and holds it until the next pop.
- R7: A pop on an empty buffer sets `pop_data_o` to 0 and leaves the buffer unchanged.
- R8: A push and a pop on the same edge leave the count unchanged when the buffer is non-empty (including full, where no overrun is raised); on an empty buffer the push is stored and the pop returns 0.
- R9: `sent_o` sets on an edge with `last_i` high while `mode_i` is transmit, and is low after any edge where `mode_i` is not transmit.
- R10: `ready_o` sets on an edge with `last_i` high in receive mode when the checksum gate passes: `crc_good_i` high, or `crc_en_i` low, or `crc_keep_i` high. Otherwise it clears on the edge the buffer becomes (or stays) empty.
- R11: `crc_ok_o` sets on an edge with `last_i` and `crc_good_i` high in receive mode, and clears on the edge the buffer becomes (or stays) empty.
- R12: While `rst_n` is low all flags are low, the buffer is empty and `pop_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode (00 sleep, 01 idle, 10 receive, 11 transmit) |
| thresh_i | input | 7 | Fill-level threshold |
| push_i | input | 1 | Write strobe |
| push_data_i | input | 8 | Write byte |
| pop_i | input | 1 | Read strobe |
| pop_data_o | output | 8 | Byte returned by the last pop |
| ovr_clr_i | input | 1 | Host write-one to the overrun flag; flushes the buffer |
| last_i | input | 1 | Final byte of a packet moved |
| crc_good_i | input | 1 | Payload checksum verdict |
| crc_en_i | input | 1 | Checksum checking enabled |
| crc_keep_i | input | 1 | Bad checksum does not block the ready flag |
| full_o | output | 1 | 66 bytes stored |
| nempty_o | output | 1 | At least one byte stored |
| level_o | output | 1 | Count above threshold |
| overrun_o | output | 1 | Write lost to a full buffer |
| sent_o | output | 1 | Transmitted packet complete |
| ready_o | output | 1 | Received payload ready |
| crc_ok_o | output | 1 | Received checksum good |

## Verification
The assertions take for granted that every strobe and the mode are driven to known levels on each edge after reset, and that the packet engine raises `last_i` in the mode it belongs to; they make no assumption about which strobes combine. The stimulus therefore draws push, pop, flush, mode, threshold and the packet-end signals independently each cycle, with pop and push weights varied so the buffer swings between empty and full, and keeps flush and packet-end pulses rare so the flags live long enough to be observed.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_IDLE  = 2'b01,
    MODE_RX    = 2'b10,
    MODE_TX    = 2'b11
  } pf_mode_e;

  function automatic int unsigned cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/pf_store.sv
module pf_store
  import pkt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 66,
  parameter int unsigned W     = 8,
  localparam int unsigned CNT_W = cnt_bits(DEPTH),
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_nxt_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     rdata_q, rdata_d;
  logic             pop_acc, push_acc, rdata_en;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    pop_acc  = pop_i && (cnt_q != '0) && !flush_i;
    push_acc = push_i && !flush_i && ((cnt_q != FULL_CNT) || pop_acc);
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    rdata_en = 1'b0;
    rdata_d  = rdata_q;
    if (flush_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (pop_acc)  rd_ptr_d = ptr_inc(rd_ptr_q);
      if (push_acc) wr_ptr_d = ptr_inc(wr_ptr_q);
      case ({push_acc, pop_acc})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
      if (pop_i) begin
        rdata_en = 1'b1;
        rdata_d  = pop_acc ? mem[rd_ptr_q] : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign rdata_o     = rdata_q;
  assign count_o     = cnt_q;
  assign count_nxt_o = cnt_d;

  // R1: occupancy never exceeds the capacity
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R1: a lone push on a full buffer changes nothing stored
  a_r1_full_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !flush_i && cnt_q == FULL_CNT)
      |=> ($stable(wr_ptr_q) && cnt_q == FULL_CNT));
  // R5: flush empties the buffer
  a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cnt_q == '0 && rd_ptr_q == wr_ptr_q));
  // R7: pop on empty leaves pointers alone
  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !flush_i && cnt_q == '0)
      |=> (cnt_q == '0 && $stable(rd_ptr_q) && rdata_q == '0));
  // R8: balanced traffic keeps occupancy
  a_r8_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !flush_i && cnt_q != '0) |=> $stable(cnt_q));
endmodule

// File: rtl/pf_status.sv
module pf_status
  import pkt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 66,
  localparam int unsigned CNT_W = cnt_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pf_mode_e         mode_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic             full_o,
  output logic             nempty_o,
  output logic             level_o,
  output logic             overrun_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic ovr_q, ovr_d, ovr_evt;

  always_comb begin
    full_o   = (count_i == FULL_CNT);
    nempty_o = (count_i != '0);
    level_o  = (count_i > thresh_i);
    ovr_evt  = push_i && !pop_i && full_o && (mode_i != MODE_SLEEP);
    ovr_d    = ovr_q;
    if (flush_i)      ovr_d = 1'b0;
    else if (ovr_evt) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign overrun_o = ovr_q;

  // R4: sleep mode never raises the overrun flag
  a_r4_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_SLEEP && !ovr_q) |=> !ovr_q);
  // R4: the flag only rises after a push into a full buffer
  a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> ($past(push_i) && $past(count_i) == FULL_CNT));
  // R5: host clear drops the flag
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !ovr_q);
endmodule

// File: rtl/pf_pkt_flags.sv
module pf_pkt_flags
  import pkt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 66,
  localparam int unsigned CNT_W = cnt_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pf_mode_e         mode_i,
  input  logic [CNT_W-1:0] count_nxt_i,
  input  logic             last_i,
  input  logic             crc_good_i,
  input  logic             crc_en_i,
  input  logic             crc_keep_i,
  output logic             sent_o,
  output logic             ready_o,
  output logic             crc_ok_o
);
  logic sent_q, sent_d, rdy_q, rdy_d, crc_q, crc_d;
  logic rx_end, gate_ok, drains;

  always_comb begin
    rx_end  = last_i && (mode_i == MODE_RX);
    gate_ok = crc_good_i || !crc_en_i || crc_keep_i;
    drains  = (count_nxt_i == '0);

    sent_d = sent_q;
    if (mode_i != MODE_TX) sent_d = 1'b0;
    else if (last_i)       sent_d = 1'b1;

    rdy_d = rdy_q;
    if (rx_end && gate_ok) rdy_d = 1'b1;
    else if (drains)       rdy_d = 1'b0;

    crc_d = crc_q;
    if (rx_end && crc_good_i) crc_d = 1'b1;
    else if (drains)          crc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= 1'b0;
      rdy_q  <= 1'b0;
      crc_q  <= 1'b0;
    end else begin
      sent_q <= sent_d;
      rdy_q  <= rdy_d;
      crc_q  <= crc_d;
    end
  end

  assign sent_o   = sent_q;
  assign ready_o  = rdy_q;
  assign crc_ok_o = crc_q;

  // R9: leaving transmit drops packet-sent
  a_r9_sent_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_TX) |=> !sent_q);
  // R10: payload-ready only rises on a receive packet end
  a_r10_ready_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> ($past(last_i) && $past(mode_i) == MODE_RX));
  // R11: checksum-ok only rises on a good receive verdict
  a_r11_crc_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_q) |-> ($past(crc_good_i) && $past(mode_i) == MODE_RX));
endmodule

// File: rtl/pkt_fifo_flags.sv
module pkt_fifo_flags
  import pkt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 66,
  parameter int unsigned W     = 8,
  localparam int unsigned CNT_W = cnt_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             pop_i,
  output logic [W-1:0]     pop_data_o,
  input  logic             ovr_clr_i,
  input  logic             last_i,
  input  logic             crc_good_i,
  input  logic             crc_en_i,
  input  logic             crc_keep_i,
  output logic             full_o,
  output logic             nempty_o,
  output logic             level_o,
  output logic             overrun_o,
  output logic             sent_o,
  output logic             ready_o,
  output logic             crc_ok_o
);
  pf_mode_e         mode;
  logic [CNT_W-1:0] count, count_nxt;

  assign mode = pf_mode_e'(mode_i);

  pf_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .flush_i     (ovr_clr_i),
    .wdata_i     (push_data_i),
    .rdata_o     (pop_data_o),
    .count_o     (count),
    .count_nxt_o (count_nxt)
  );

  pf_status #(.DEPTH(DEPTH)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .count_i   (count),
    .thresh_i  (thresh_i),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .flush_i   (ovr_clr_i),
    .full_o    (full_o),
    .nempty_o  (nempty_o),
    .level_o   (level_o),
    .overrun_o (overrun_o)
  );

  pf_pkt_flags #(.DEPTH(DEPTH)) u_pkt (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .count_nxt_i (count_nxt),
    .last_i      (last_i),
    .crc_good_i  (crc_good_i),
    .crc_en_i    (crc_en_i),
    .crc_keep_i  (crc_keep_i),
    .sent_o      (sent_o),
    .ready_o     (ready_o),
    .crc_ok_o    (crc_ok_o)
  );

  // R2: holding data and being full never disagree
  a_r2_full_implies_data: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> nempty_o);
endmodule

// File: tb/sim_pkt_fifo_flags.sv
`timescale 1ns/1ps
module sim_pkt_fifo_flags;
  localparam int DEPTH = 66;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic [6:0] thresh;
  logic       push, pop, clr, last, good, en, keep;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       full, nempty, level, ovr, sent, rdy, crcok;

  int total = 0;
  int bad   = 0;

  // reference model
  byte unsigned q[$];
  bit   m_ovr, m_sent, m_rdy, m_crc;
  logic [7:0] m_rdata;

  always #4 clk = ~clk;

  pkt_fifo_flags u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .thresh_i(thresh),
    .push_i(push), .push_data_i(wdata), .pop_i(pop), .pop_data_o(rdata),
    .ovr_clr_i(clr), .last_i(last), .crc_good_i(good), .crc_en_i(en),
    .crc_keep_i(keep), .full_o(full), .nempty_o(nempty), .level_o(level),
    .overrun_o(ovr), .sent_o(sent), .ready_o(rdy), .crc_ok_o(crcok)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit gate(input bit g, input bit e, input bit k);
    return g || !e || k;
  endfunction

  task automatic model_step();
    int sz;
    bit popped;
    if (clr) begin
      q.delete();
      m_ovr = 0;
    end else begin
      sz = q.size();
      popped = pop && sz > 0;
      if (pop) m_rdata = popped ? q.pop_front() : 8'h00;
      if (push && q.size() < DEPTH) q.push_back(wdata);
      if (push && !pop && sz == DEPTH && mode != 2'b00) m_ovr = 1;
    end
    if (mode != 2'b11) m_sent = 0;
    else if (last)     m_sent = 1;
    if (last && mode == 2'b10 && gate(good, en, keep)) m_rdy = 1;
    else if (q.size() == 0) m_rdy = 0;
    if (last && mode == 2'b10 && good) m_crc = 1;
    else if (q.size() == 0) m_crc = 0;
  endtask

  task automatic compare_all();
    chk("R1 full",    full,   q.size() == DEPTH);
    chk("R2 nempty",  nempty, q.size() != 0);
    chk("R3 level",   level,  q.size() > thresh);
    chk("R4 overrun", ovr,    m_ovr);
    chk("R6 rdata",   rdata,  m_rdata);
    chk("R9 sent",    sent,   m_sent);
    chk("R10 ready",  rdy,    m_rdy);
    chk("R11 crcok",  crcok,  m_crc);
  endtask

  task automatic idle_in();
    push = 0; pop = 0; clr = 0; last = 0; good = 0; en = 1; keep = 0;
    wdata = 8'h00;
  endtask

  // apply current inputs for one edge, then compare at the falling edge
  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle_in();
  endtask

  task automatic do_push(input logic [7:0] d);
    push = 1; wdata = d; step();
  endtask

  task automatic do_pop();
    pop = 1; step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; mode = 2'b10; thresh = 7'd10; idle_in();
    m_ovr = 0; m_sent = 0; m_rdy = 0; m_crc = 0; m_rdata = 8'h00;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 full", full, 0);  chk("R12 nempty", nempty, 0);
    chk("R12 ovr", ovr, 0);    chk("R12 rdata", rdata, 0);
    chk("R12 ready", rdy, 0);  chk("R12 sent", sent, 0);
    rst_n = 1;
    @(negedge clk);

    // R7: pop on empty returns zero
    do_pop();
    chk("R7 empty pop data", rdata, 0);

    // R3: equality at threshold does not set level
    thresh = 7'd3;
    for (int i = 0; i < 3; i++) do_push(8'(i + 1));
    chk("R3 equal threshold", level, 0);
    do_push(8'h44);
    chk("R3 above threshold", level, 1);

    // R1: fill to capacity
    for (int i = 4; i < DEPTH; i++) do_push(8'(i + 1));
    chk("R1 full at 66", full, 1);

    // R4 with sleep mode: discarded, no flag
    mode = 2'b00; do_push(8'hEE);
    chk("R4 sleep no overrun", ovr, 0);
    chk("R1 still full", full, 1);
    // R4 in receive: flag set
    mode = 2'b10; do_push(8'hEF);
    chk("R4 overrun set", ovr, 1);

    // R8: push and pop on full: count unchanged, no new overrun effect
    push = 1; pop = 1; wdata = 8'h99; step();
    chk("R8 full both", full, 1);
    // R6: the oldest byte came out
    chk("R6 first byte", rdata, 8'h01);

    // R10/R11: packet end with good checksum
    last = 1; good = 1; step();
    chk("R10 ready set", rdy, 1);
    chk("R11 crc set", crcok, 1);

    // R5: flush clears flag and buffer, ignores pop
    clr = 1; pop = 1; push = 1; step();
    chk("R5 flush empty", nempty, 0);
    chk("R5 flush overrun", ovr, 0);
    chk("R10 ready cleared by empty", rdy, 0);

    // R10: bad checksum blocks ready unless keep
    last = 1; good = 0; en = 1; keep = 0; step();
    chk("R10 gate blocks", rdy, 0);
    do_push(8'h10);
    last = 1; good = 0; en = 1; keep = 1; step();
    chk("R10 keep passes", rdy, 1);
    chk("R11 crc stays low", crcok, 0);
    do_pop();
    chk("R10 drain clears", rdy, 0);

    // R9: sent in transmit, cleared on exit
    mode = 2'b11; last = 1; step();
    chk("R9 sent set", sent, 1);
    mode = 2'b01; step();
    chk("R9 sent cleared", sent, 0);

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      int unsigned r;
      int bias;
      bias = (n / 500) % 2 == 0 ? 70 : 35;
      r = $urandom();
      push  = ($urandom_range(99) < bias);
      pop   = ($urandom_range(99) < 100 - bias);
      wdata = 8'($urandom());
      clr   = ($urandom_range(199) == 0);
      last  = ($urandom_range(29) == 0);
      good  = r[0]; en = r[1]; keep = r[2];
      mode  = (r[7:4] < 4'd11) ? 2'b10 : 2'(r[9:8]);
      if (r[15:12] == 4'd0) thresh = 7'($urandom_range(DEPTH));
      step();
    end
    chk("R8 random balanced done", 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : seed
    int unsigned s;
    s = $urandom(32'h1234_5678);
  end
endmodule